// File: doc/BRIEF.md
# Microcoded Control Sequencer for an 8-bit Accumulator Machine

This block is the control unit of a small 8-bit accumulator computer. Each clock it produces a 17-bit control word of enable lines for the datapath. These lines cover bus drivers, register loads, the ALU subtract select, program counter count and load, the display latch, the flag latch and a halt line. The word comes from a microcode array inside the block. The array is addressed by the 4-bit opcode held in the instruction register, the current micro-step, and the two stored condition flags.

Every instruction takes five micro-steps, T1 to T5. The first two steps are a fetch that is the same for every opcode. The other three steps depend on the opcode. The carry and zero bits from the ALU are latched inside the block only in a step that asks for it. The conditional jumps read these latched bits. Once a halt word is reached, the block stays frozen until a synchronous reset.

All pins are plain control and status wires. No data stream passes through this block, so there is no valid/ready handshake and no back-pressure.

Top module: `ucode_sequencer`

## Requirements
- R1: A step counter runs T1, T2, T3, T4, T5. It advances one step per rising clock edge and returns to T1 after T5, while the block is not halted.
- R2: In T1 the word is PC_OE|MAR_LD (0x00003). In T2 the word is RAM_OE|IR_LD|PC_INC (0x0001C). These two words are the same for every opcode and every flag state.
- R3: The bit positions of `ctrl_o` are: 0 PC_OE, 1 MAR_LD, 2 RAM_OE, 3 IR_LD, 4 PC_INC, 5 IR_OE, 6 ACC_LD, 7 ACC_OE, 8 BREG_LD, 9 BREG_OE, 10 ALU_OE, 11 ALU_SUB, 12 FLAG_LD, 13 RAM_WE, 14 PC_LD, 15 OUT_LD, 16 HALT. BREG_OE is never asserted.
- R4: The opcodes are nop 0000, lda 0001, add 0010, sub 0011, sta 0100, ldi 0101, jmp 0110, jc 0111, jz 1000, out 1110 and hlt 1111. The words for T3/T4/T5 are:
  - lda: 0x22 / 0x44 / 0
  - sta: 0x22 / 0x2080 / 0
  - ldi: 0x60 / 0 / 0
  - out: 0x8080 / 0 / 0
  - nop: 0 / 0 / 0
- R5: add gives 0x22 in T3, 0x104 in T4 and ALU_OE|ACC_LD|FLAG_LD (0x1440) in T5. sub is the same except that T5 also sets ALU_SUB (0x1C40).
- R6: The stored carry and zero flags take `alu_carry_i` and `alu_zero_i` at a rising edge where FLAG_LD is high. At every other edge they keep their value.
- R7: jmp gives IR_OE|PC_LD (0x4020) in T3. jc gives 0x4020 in T3 only when the stored carry is set, and jz only when the stored zero is set; otherwise T3 is 0. T4 and T5 are 0 for all three jumps.
- R8: hlt gives HALT (0x10000) in T3. From then on the word stays 0x10000 and the step stays frozen, whatever the opcode input does, until reset.
- R9: The opcodes that are not listed in R4 (1001 to 1101) behave as nop. They never change the stored flags.
- R10: A synchronous reset returns the step to T1, clears both stored flags and ends a halt. This also applies to a reset in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 4 | Upper nibble of the instruction register |
| alu_carry_i | input | 1 | Carry out of the ALU |
| alu_zero_i | input | 1 | High when the ALU result is zero |
| ctrl_o | output | 17 | Control word for the current micro-step (bit map in R3) |

## Verification
A wrong step count shows at once. A stuck or skipped step puts a fetch word where an execute word is due, or the reverse, in the very next cycle. A flag latched at the wrong edge does not show until a later jc or jz: its T3 word is 0x4020 where 0 is due, or the reverse. A halt that leaks or a reset that does not clear shows in the first word after the event.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CW     = 17;
  localparam int NSTEPS = 5;
  localparam int OP_W   = 4;

  // control word bit positions
  localparam int B_PC_OE   = 0;
  localparam int B_MAR_LD  = 1;
  localparam int B_RAM_OE  = 2;
  localparam int B_IR_LD   = 3;
  localparam int B_PC_INC  = 4;
  localparam int B_IR_OE   = 5;
  localparam int B_ACC_LD  = 6;
  localparam int B_ACC_OE  = 7;
  localparam int B_BREG_LD = 8;
  localparam int B_BREG_OE = 9;
  localparam int B_ALU_OE  = 10;
  localparam int B_ALU_SUB = 11;
  localparam int B_FLAG_LD = 12;
  localparam int B_RAM_WE  = 13;
  localparam int B_PC_LD   = 14;
  localparam int B_OUT_LD  = 15;
  localparam int B_HALT    = 16;

  localparam logic [OP_W-1:0] OP_NOP = 4'h0;
  localparam logic [OP_W-1:0] OP_LDA = 4'h1;
  localparam logic [OP_W-1:0] OP_ADD = 4'h2;
  localparam logic [OP_W-1:0] OP_SUB = 4'h3;
  localparam logic [OP_W-1:0] OP_STA = 4'h4;
  localparam logic [OP_W-1:0] OP_LDI = 4'h5;
  localparam logic [OP_W-1:0] OP_JMP = 4'h6;
  localparam logic [OP_W-1:0] OP_JC  = 4'h7;
  localparam logic [OP_W-1:0] OP_JZ  = 4'h8;
  localparam logic [OP_W-1:0] OP_OUT = 4'hE;
  localparam logic [OP_W-1:0] OP_HLT = 4'hF;

  typedef logic [CW-1:0] cword_t;

  // One microcode entry: opcode, step index (0 = T1), stored carry and zero.
  function automatic cword_t ucode_word(input logic [OP_W-1:0] op, input int st,
                                        input logic cf, input logic zf);
    cword_t w;
    w = '0;
    if (st == 0) begin
      w[B_PC_OE] = 1'b1; w[B_MAR_LD] = 1'b1;
    end else if (st == 1) begin
      w[B_RAM_OE] = 1'b1; w[B_IR_LD] = 1'b1; w[B_PC_INC] = 1'b1;
    end else if (st == 2) begin
      case (op)
        OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
          w[B_IR_OE] = 1'b1; w[B_MAR_LD] = 1'b1;
        end
        OP_LDI: begin w[B_IR_OE] = 1'b1; w[B_ACC_LD] = 1'b1; end
        OP_JMP: begin w[B_IR_OE] = 1'b1; w[B_PC_LD] = 1'b1; end
        OP_JC:  begin w[B_IR_OE] = cf;   w[B_PC_LD] = cf;   end
        OP_JZ:  begin w[B_IR_OE] = zf;   w[B_PC_LD] = zf;   end
        OP_OUT: begin w[B_ACC_OE] = 1'b1; w[B_OUT_LD] = 1'b1; end
        OP_HLT: w[B_HALT] = 1'b1;
        default: w = '0;
      endcase
    end else if (st == 3) begin
      case (op)
        OP_LDA: begin w[B_RAM_OE] = 1'b1; w[B_ACC_LD] = 1'b1; end
        OP_ADD, OP_SUB: begin w[B_RAM_OE] = 1'b1; w[B_BREG_LD] = 1'b1; end
        OP_STA: begin w[B_ACC_OE] = 1'b1; w[B_RAM_WE] = 1'b1; end
        default: w = '0;
      endcase
    end else if (st == 4) begin
      if (op == OP_ADD || op == OP_SUB) begin
        w[B_ALU_OE]  = 1'b1;
        w[B_ACC_LD]  = 1'b1;
        w[B_FLAG_LD] = 1'b1;
        w[B_ALU_SUB] = (op == OP_SUB);
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/useq_step_ctr.sv
module useq_step_ctr #(
  parameter int STEPS  = 5,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst)             step <= '0;
    else if (!hold)      step <= (step == LAST) ? '0 : step + 1'b1;
  end
endmodule

// File: rtl/useq_flags.sv
module useq_flags (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic carry_in,
  input  logic zero_in,
  output logic carry_q,
  output logic zero_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (load) begin
      carry_q <= carry_in;
      zero_q  <= zero_in;
    end
  end
endmodule

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int STEPS  = NSTEPS,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic [OP_W-1:0]   op,
  input  logic [STEP_W-1:0] step,
  input  logic              cf,
  input  logic              zf,
  output cword_t            word
);
  localparam int ADDR_W = OP_W + STEP_W + 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NOPS   = 1 << OP_W;
  localparam int NROWS  = 1 << STEP_W;

  cword_t rom [DEPTH];

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    for (genvar s = 0; s < NROWS; s++) begin : g_step
      for (genvar f = 0; f < 4; f++) begin : g_flag
        localparam int IDX = (o << (STEP_W + 2)) | (s << 2) | f;
        if (s < STEPS) begin : g_used
          assign rom[IDX] = ucode_word(OP_W'(o), s, 1'((f >> 1) & 1), 1'(f & 1));
        end else begin : g_free
          assign rom[IDX] = '0;
        end
      end
    end
  end

  assign word = rom[{op, step, cf, zf}];
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import useq_pkg::*;
#(
  parameter int STEPS  = NSTEPS,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            alu_carry_i,
  input  logic            alu_zero_i,
  output logic [CW-1:0]   ctrl_o
);
  logic [STEP_W-1:0] step_q;
  logic              carry_q, zero_q;
  logic              halt_q;
  cword_t            rom_word;
  cword_t            halt_word;

  assign halt_word = cword_t'(1) << B_HALT;

  useq_step_ctr #(.STEPS(STEPS), .STEP_W(STEP_W)) u_step (
    .clk (clk),
    .rst (rst),
    .hold(ctrl_o[B_HALT]),
    .step(step_q)
  );

  useq_rom #(.STEPS(STEPS), .STEP_W(STEP_W)) u_rom (
    .op  (opcode_i),
    .step(step_q),
    .cf  (carry_q),
    .zf  (zero_q),
    .word(rom_word)
  );

  useq_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .load    (ctrl_o[B_FLAG_LD]),
    .carry_in(alu_carry_i),
    .zero_in (alu_zero_i),
    .carry_q (carry_q),
    .zero_q  (zero_q)
  );

  // halt latch: once a HALT word is issued the word is pinned until reset
  always_ff @(posedge clk) begin
    if (rst)                  halt_q <= 1'b0;
    else if (rom_word[B_HALT]) halt_q <= 1'b1;
  end

  assign ctrl_o = halt_q ? halt_word : rom_word;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
#(
  parameter int STEPS  = NSTEPS,
  parameter int STEP_W = $clog2(STEPS)
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     ctrl,
  input logic [STEP_W-1:0] step,
  input logic              carry,
  input logic              zero,
  input logic              alu_c,
  input logic              alu_z
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  assert_step_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[B_HALT] && step == LAST) |=> step == '0);

  assert_step_incr_R1: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[B_HALT] && step < LAST) |=> step == $past(step) + 1'b1);

  assert_fetch_t1_R2: assert property (@(posedge clk) disable iff (rst)
    step == '0 |-> ctrl == 17'h00003);

  assert_fetch_t2_R2: assert property (@(posedge clk) disable iff (rst)
    step == STEP_W'(1) |-> ctrl == 17'h0001C);

  assert_no_breg_drive_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl[B_BREG_OE]);

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrl[B_FLAG_LD] |=> $stable(carry) && $stable(zero));

  assert_flag_take_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl[B_FLAG_LD] |=> carry == $past(alu_c) && zero == $past(alu_z));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl[B_HALT] |=> ctrl[B_HALT] && $stable(step) && $countones(ctrl) == 1);

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> step == '0 && !carry && !zero && !ctrl[B_HALT]);
endmodule

bind ucode_sequencer useq_checker #(.STEPS(STEPS), .STEP_W(STEP_W)) u_useq_checker (
  .clk  (clk),
  .rst  (rst),
  .ctrl (ctrl_o),
  .step (step_q),
  .carry(carry_q),
  .zero (zero_q),
  .alu_c(alu_carry_i),
  .alu_z(alu_zero_i)
);

// File: tb/test_ucode_sequencer.sv
`timescale 1ns/1ps
module test_ucode_sequencer;
  localparam int CLK_PERIOD = 20;
  localparam logic [16:0] W_T1 = 17'h00003;
  localparam logic [16:0] W_T2 = 17'h0001C;
  localparam logic [16:0] W_HLT = 17'h10000;

  typedef struct packed {
    logic [3:0]  op;
    logic        c;
    logic        z;
    logic [7:0]  req;
    logic [16:0] t3;
    logic [16:0] t4;
    logic [16:0] t5;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'h0, 1'b0, 1'b0, 8'd4, 17'h0,    17'h0,    17'h0},     // R4 nop
    '{4'h1, 1'b0, 1'b0, 8'd4, 17'h22,   17'h44,   17'h0},     // R4 lda
    '{4'h2, 1'b1, 1'b0, 8'd5, 17'h22,   17'h104,  17'h1440},  // R5 add, flags c=1 z=0
    '{4'h7, 1'b0, 1'b0, 8'd7, 17'h4020, 17'h0,    17'h0},     // R7 jc taken
    '{4'h8, 1'b0, 1'b0, 8'd7, 17'h0,    17'h0,    17'h0},     // R7 jz not taken
    '{4'h3, 1'b0, 1'b1, 8'd5, 17'h22,   17'h104,  17'h1C40},  // R5 sub, flags c=0 z=1
    '{4'h7, 1'b1, 1'b1, 8'd6, 17'h0,    17'h0,    17'h0},     // R6 jc not taken, no latch
    '{4'h8, 1'b0, 1'b0, 8'd7, 17'h4020, 17'h0,    17'h0},     // R7 jz taken
    '{4'h4, 1'b0, 1'b0, 8'd4, 17'h22,   17'h2080, 17'h0},     // R4 sta
    '{4'h5, 1'b0, 1'b0, 8'd4, 17'h60,   17'h0,    17'h0},     // R4 ldi
    '{4'h6, 1'b0, 1'b0, 8'd7, 17'h4020, 17'h0,    17'h0},     // R7 jmp
    '{4'hE, 1'b0, 1'b0, 8'd4, 17'h8080, 17'h0,    17'h0},     // R4 out
    '{4'h9, 1'b1, 1'b0, 8'd9, 17'h0,    17'h0,    17'h0},     // R9 undefined opcode
    '{4'h8, 1'b0, 1'b0, 8'd9, 17'h4020, 17'h0,    17'h0},     // R9 zero flag kept after 1001
    '{4'h2, 1'b1, 1'b1, 8'd5, 17'h22,   17'h104,  17'h1440},  // R5 add, flags c=1 z=1
    '{4'h7, 1'b0, 1'b0, 8'd6, 17'h4020, 17'h0,    17'h0},     // R6 carry latched
    '{4'hD, 1'b0, 1'b0, 8'd9, 17'h0,    17'h0,    17'h0}      // R9 undefined 1101
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'h0;
  logic        alu_c = 1'b0;
  logic        alu_z = 1'b0;
  logic [16:0] ctrl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ucode_sequencer i_ucode_sequencer (
    .clk        (clk),
    .rst        (rst),
    .opcode_i   (opcode),
    .alu_carry_i(alu_c),
    .alu_zero_i (alu_z),
    .ctrl_o     (ctrl)
  );

  // drive at the falling edge, compare just after; one rising edge between calls
  task automatic chk(input logic [3:0] op, input logic c, input logic z,
                     input logic [16:0] exp, input string tag);
    @(negedge clk);
    opcode = op;
    alu_c  = c;
    alu_z  = z;
    #1;
    checks++;
    if (ctrl !== exp) begin
      fails++;
      $display("FAIL %s op=%h actual=%h expected=%h", tag, op, ctrl, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic run_instr(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    chk(v.op, v.c, v.z, W_T1, "R1/R2 fetch T1");
    chk(v.op, v.c, v.z, W_T2, "R2 fetch T2");
    chk(v.op, v.c, v.z, v.t3, tag);
    chk(v.op, v.c, v.z, v.t4, tag);
    chk(v.op, v.c, v.z, v.t5, tag);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;

    // R10 reset state: T1 word first
    for (int i = 0; i < NV; i++) run_instr(VEC[i]);

    // R8 halt: freeze, ignore opcode changes
    chk(4'hF, 1'b0, 1'b0, W_T1, "R8 T1");
    chk(4'hF, 1'b0, 1'b0, W_T2, "R8 T2");
    chk(4'hF, 1'b0, 1'b0, W_HLT, "R8 halt word");
    for (int k = 0; k < 6; k++) chk(4'h6, 1'b1, 1'b1, W_HLT, "R8 held");

    // R10 reset releases halt and clears flags (they were c=1 z=1)
    do_reset();
    chk(4'h7, 1'b0, 1'b0, W_T1, "R10 after halt");
    chk(4'h7, 1'b0, 1'b0, W_T2, "R10 T2");
    chk(4'h7, 1'b0, 1'b0, 17'h0, "R10 carry cleared");
    chk(4'h7, 1'b0, 1'b0, 17'h0, "R10 T4");
    chk(4'h7, 1'b0, 1'b0, 17'h0, "R10 T5");
    chk(4'h8, 1'b0, 1'b0, W_T1, "R10 T1");
    chk(4'h8, 1'b0, 1'b0, W_T2, "R10 T2");
    chk(4'h8, 1'b0, 1'b0, 17'h0, "R10 zero cleared");

    // R10 reset mid-instruction
    do_reset();
    chk(4'h1, 1'b0, 1'b0, W_T1, "R10 T1");
    chk(4'h1, 1'b0, 1'b0, W_T2, "R10 T2");
    chk(4'h1, 1'b0, 1'b0, 17'h22, "R4 lda T3");
    do_reset();
    chk(4'h1, 1'b0, 1'b0, W_T1, "R10 mid-instruction reset");
    chk(4'h1, 1'b0, 1'b0, W_T2, "R1 next step");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule